// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block owns the processor status fields that change when a trap is taken and when a handler returns. These fields are the trap-enable flag, the supervisor flag, the previous-supervisor flag, the current window pointer and the trap type. It accepts three kinds of request: a hardware trap carrying an 8-bit trap type, a software trap carrying a 7-bit argument, and a return command. A return carries the pc left by the jump that must come before it and the npc operand of the return itself.

On entry the block updates the status fields first. It then issues three consecutive register-file writes into local slots 0, 1 and 2 of the new window, saving the trapped pc, the trapped npc and the status word as it was before the trap. Last, it presents a one-cycle fetch strobe whose pc is the trap base address and whose npc is that address plus four. A return completes in a single step. An entry request that arrives while traps are disabled halts the sequencer and raises a fatal output that only reset clears. A return issued from user mode, or issued while traps are enabled, is turned into a trap of its own.

Top module: `trap_seq`

## Requirements
- R1: After reset, et_o=1, s_o=RST_SUPER (0 by default), ps_o=0, cwp_o=0, the trap-type field of tbr_o is 0, and busy_o, fatal_o, rf_we_o and fetch_o are all 0.
- R2: In the cycle after a trap is accepted, et_o=0, ps_o holds the earlier s_o, s_o=1, and cwp_o has been decremented modulo NWIN, so 0 becomes NWIN-1.
- R3: In the three cycles after acceptance, rf_we_o=1 with rf_idx_o equal to 0, 1 and 2, and rf_data_o equal to the trapped pc_i, the trapped npc_i, and the status word from before entry. In that word bit 7 is S, bit 6 is PS, bit 5 is ET, bits [CWP_W-1:0] hold CWP, and all other bits are 0. rf_win_o equals the new cwp_o.
- R4: tbr_o = {tba_i, tt, 4'b0000}. In the cycle after the third save, fetch_o=1 for one cycle with fetch_pc_o=tbr_o and fetch_npc_o=tbr_o+4.
- R5: A software trap uses trap type 8'h80 | arg[6:0]. If a hardware trap, a software trap and a return arrive in the same idle cycle, the hardware trap is taken first, then the software trap, then the return.
- R6: An accepted trap that finds et_o=0 performs no writes and no fetch and leaves the status unchanged. fatal_o rises in the next cycle and stays high until reset.
- R7: A return with s_o=1 and et_o=0 drives fetch_o=1 in the next cycle with fetch_pc_o=ret_pc_i and fetch_npc_o=ret_npc_i. In that same cycle et_o=1, s_o equals the earlier ps_o, and cwp_o has been incremented modulo NWIN, so NWIN-1 becomes 0.
- R8: A return with s_o=0 is taken as a trap of type 8'h03. A return with s_o=1 and et_o=1 is taken as a trap of type 8'h02. Both follow the entry rules in R2 to R4, and the pc_i they save is the pc of the return itself.
- R9: While busy_o=1, all requests are ignored and the status fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Hardware trap request |
| trap_tt_i | input | 8 | Hardware trap type |
| sw_trap_i | input | 1 | Software trap request |
| sw_arg_i | input | 7 | Software trap argument |
| ret_req_i | input | 1 | Return command |
| ret_pc_i | input | XLEN | pc supplied by the preceding jump |
| ret_npc_i | input | XLEN | npc operand of the return |
| pc_i | input | XLEN | pc of the current instruction |
| npc_i | input | XLEN | npc of the current instruction |
| tba_i | input | XLEN-12 | Trap base address, upper field |
| busy_o | output | 1 | Entry or return sequence in progress |
| fatal_o | output | 1 | Trap taken with traps disabled; held until reset |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_win_o | output | CWP_W | Window of the write |
| rf_idx_o | output | 2 | Local register index of the write |
| rf_data_o | output | XLEN | Write data |
| fetch_o | output | 1 | New pc/npc are valid |
| fetch_pc_o | output | XLEN | New pc |
| fetch_npc_o | output | XLEN | New npc |
| et_o | output | 1 | Trap enable |
| s_o | output | 1 | Supervisor |
| ps_o | output | 1 | Previous supervisor |
| cwp_o | output | CWP_W | Current window pointer |
| tbr_o | output | XLEN | Trap base register |

## Verification
The bench builds the main instance with XLEN=32, NWIN=8 and RST_SUPER=0. This reset leaves the block in user mode with traps enabled, so a return issued at once takes the privileged path, and the trap that follows drives the window pointer from 0 across the wrap to 7. A second instance built with RST_SUPER=1 starts in supervisor mode with traps enabled. It is the only way to reach the illegal-return path, because every later state with traps enabled inherits its supervisor flag from a user-mode start.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {S_IDLE, S_SV_PC, S_SV_NPC, S_SV_PSR, S_LOAD, S_HALT} seq_e;
  typedef enum logic [1:0] {C_NONE, C_TRAP, C_RET, C_FATAL} cmd_e;

  localparam int unsigned TT_W = 8;
  localparam logic [TT_W-1:0] TT_ILLEGAL    = 8'h02;
  localparam logic [TT_W-1:0] TT_PRIVILEGED = 8'h03;
  localparam logic [TT_W-1:0] TT_SW_BASE    = 8'h80;

  // status word bit positions
  localparam int unsigned PSR_S  = 7;
  localparam int unsigned PSR_PS = 6;
  localparam int unsigned PSR_ET = 5;
endpackage

// File: rtl/trap_cause.sv
module trap_cause
  import trap_pkg::*;
(
  input  logic            idle_i,
  input  logic            trap_req_i,
  input  logic [TT_W-1:0] trap_tt_i,
  input  logic            sw_trap_i,
  input  logic [TT_W-2:0] sw_arg_i,
  input  logic            ret_req_i,
  input  logic            et_i,
  input  logic            s_i,
  output cmd_e            cmd_o,
  output logic [TT_W-1:0] tt_o
);
  logic want_trap;

  always_comb begin
    want_trap = 1'b0;
    tt_o      = trap_tt_i;
    cmd_o     = C_NONE;
    if (idle_i) begin
      if (trap_req_i) begin
        want_trap = 1'b1;
      end else if (sw_trap_i) begin
        want_trap = 1'b1;
        tt_o      = TT_SW_BASE | {1'b0, sw_arg_i};
      end else if (ret_req_i) begin
        if (!s_i) begin
          want_trap = 1'b1;
          tt_o      = TT_PRIVILEGED;
        end else if (et_i) begin
          want_trap = 1'b1;
          tt_o      = TT_ILLEGAL;
        end else begin
          cmd_o = C_RET;
        end
      end
      if (want_trap) cmd_o = et_i ? C_TRAP : C_FATAL;
    end
  end
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NWIN      = 8,
  parameter int unsigned CWP_W     = $clog2(NWIN),
  parameter bit          RST_SUPER = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [TT_W-1:0]  tt_i,
  output logic             et_o,
  output logic             s_o,
  output logic             ps_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [XLEN-1:0]  psr_o
);
  localparam logic [CWP_W-1:0] CWP_TOP = CWP_W'(NWIN - 1);

  logic             et_q, s_q, ps_q;
  logic [CWP_W-1:0] cwp_q, cwp_dn, cwp_up;
  logic [TT_W-1:0]  tt_q;

  always_comb begin
    cwp_dn = (cwp_q == '0) ? CWP_TOP : cwp_q - CWP_W'(1);
    cwp_up = (cwp_q == CWP_TOP) ? '0 : cwp_q + CWP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      et_q  <= 1'b1;
      s_q   <= RST_SUPER;
      ps_q  <= 1'b0;
      cwp_q <= '0;
      tt_q  <= '0;
    end else begin
      case (cmd_i)
        C_TRAP: begin
          et_q  <= 1'b0;
          ps_q  <= s_q;
          s_q   <= 1'b1;
          cwp_q <= cwp_dn;
          tt_q  <= tt_i;
        end
        C_RET: begin
          et_q  <= 1'b1;
          s_q   <= ps_q;
          cwp_q <= cwp_up;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    psr_o                = '0;
    psr_o[PSR_S]         = s_q;
    psr_o[PSR_PS]        = ps_q;
    psr_o[PSR_ET]        = et_q;
    psr_o[CWP_W-1:0]     = cwp_q;
  end

  assign et_o  = et_q;
  assign s_o   = s_q;
  assign ps_o  = ps_q;
  assign cwp_o = cwp_q;
  assign tt_o  = tt_q;

  p_entry_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_TRAP) |=> (!et_q && s_q && (ps_q == $past(s_q))));
  p_cwp_wrap_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_TRAP && cwp_q == '0) |=> (cwp_q == CWP_TOP));
  p_ret_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_RET) |=> (et_q && (s_q == $past(ps_q))));
  p_cwp_wrap_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_RET && cwp_q == CWP_TOP) |=> (cwp_q == '0));
  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_NONE) |=> $stable({et_q, s_q, ps_q, cwp_q, tt_q}));
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_e            cmd_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] ret_pc_i,
  input  logic [XLEN-1:0] ret_npc_i,
  input  logic [XLEN-1:0] psr_i,
  input  logic [XLEN-1:0] tbr_i,
  output seq_e            state_o,
  output logic            rf_we_o,
  output logic [1:0]      rf_idx_o,
  output logic [XLEN-1:0] rf_data_o,
  output logic            fetch_o,
  output logic [XLEN-1:0] fetch_pc_o,
  output logic [XLEN-1:0] fetch_npc_o,
  output logic            fatal_o
);
  seq_e            st_q, st_d;
  logic [XLEN-1:0] sv_pc_q, sv_npc_q, sv_psr_q;
  logic [XLEN-1:0] f_pc_q, f_npc_q;
  logic            idle;

  assign idle = (st_q == S_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        case (cmd_i)
          C_TRAP:  st_d = S_SV_PC;
          C_RET:   st_d = S_LOAD;
          C_FATAL: st_d = S_HALT;
          default: st_d = S_IDLE;
        endcase
      end
      S_SV_PC:  st_d = S_SV_NPC;
      S_SV_NPC: st_d = S_SV_PSR;
      S_SV_PSR: st_d = S_LOAD;
      S_LOAD:   st_d = S_IDLE;
      S_HALT:   st_d = S_HALT;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      sv_pc_q  <= '0;
      sv_npc_q <= '0;
      sv_psr_q <= '0;
      f_pc_q   <= '0;
      f_npc_q  <= '0;
    end else begin
      st_q <= st_d;
      if (idle && cmd_i == C_TRAP) begin
        sv_pc_q  <= pc_i;
        sv_npc_q <= npc_i;
        sv_psr_q <= psr_i;  // status before this edge's update
      end
      if (idle && cmd_i == C_RET) begin
        f_pc_q  <= ret_pc_i;
        f_npc_q <= ret_npc_i;
      end
      if (st_q == S_SV_PSR) begin
        f_pc_q  <= tbr_i;
        f_npc_q <= tbr_i + XLEN'(4);
      end
    end
  end

  always_comb begin
    rf_we_o   = 1'b0;
    rf_idx_o  = 2'd0;
    rf_data_o = '0;
    case (st_q)
      S_SV_PC:  begin rf_we_o = 1'b1; rf_idx_o = 2'd0; rf_data_o = sv_pc_q;  end
      S_SV_NPC: begin rf_we_o = 1'b1; rf_idx_o = 2'd1; rf_data_o = sv_npc_q; end
      S_SV_PSR: begin rf_we_o = 1'b1; rf_idx_o = 2'd2; rf_data_o = sv_psr_q; end
      default: ;
    endcase
  end

  assign state_o     = st_q;
  assign fetch_o     = (st_q == S_LOAD);
  assign fetch_pc_o  = f_pc_q;
  assign fetch_npc_o = f_npc_q;
  assign fatal_o     = (st_q == S_HALT);

  p_save_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cmd_i == C_TRAP) |=> (rf_we_o && rf_idx_o == 2'd0 && rf_data_o == $past(pc_i)));
  p_save_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_idx_o != 2'd2) |=> (rf_we_o && rf_idx_o == $past(rf_idx_o) + 2'd1));
  p_handler_fetch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_idx_o == 2'd2) |=> (fetch_o && fetch_pc_o == $past(tbr_i)
                                       && fetch_npc_o == $past(tbr_i) + XLEN'(4)));
  p_fatal_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> (fatal_o && !rf_we_o && !fetch_o));
  p_ret_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cmd_i == C_RET) |=> (fetch_o && fetch_pc_o == $past(ret_pc_i)
                                  && fetch_npc_o == $past(ret_npc_i)));
  p_busy_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle) |-> (cmd_i == C_NONE));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NWIN      = 8,
  parameter bit          RST_SUPER = 1'b0,
  localparam int unsigned CWP_W    = $clog2(NWIN),
  localparam int unsigned TBA_W    = XLEN - 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_req_i,
  input  logic [7:0]       trap_tt_i,
  input  logic             sw_trap_i,
  input  logic [6:0]       sw_arg_i,
  input  logic             ret_req_i,
  input  logic [XLEN-1:0]  ret_pc_i,
  input  logic [XLEN-1:0]  ret_npc_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  npc_i,
  input  logic [TBA_W-1:0] tba_i,
  output logic             busy_o,
  output logic             fatal_o,
  output logic             rf_we_o,
  output logic [CWP_W-1:0] rf_win_o,
  output logic [1:0]       rf_idx_o,
  output logic [XLEN-1:0]  rf_data_o,
  output logic             fetch_o,
  output logic [XLEN-1:0]  fetch_pc_o,
  output logic [XLEN-1:0]  fetch_npc_o,
  output logic             et_o,
  output logic             s_o,
  output logic             ps_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [XLEN-1:0]  tbr_o
);
  cmd_e             cmd;
  seq_e             state;
  logic [TT_W-1:0]  tt_sel, tt_q;
  logic [XLEN-1:0]  psr, tbr;
  logic             et, s, ps;
  logic [CWP_W-1:0] cwp;

  trap_cause u_cause (
    .idle_i     (state == S_IDLE),
    .trap_req_i (trap_req_i),
    .trap_tt_i  (trap_tt_i),
    .sw_trap_i  (sw_trap_i),
    .sw_arg_i   (sw_arg_i),
    .ret_req_i  (ret_req_i),
    .et_i       (et),
    .s_i        (s),
    .cmd_o      (cmd),
    .tt_o       (tt_sel)
  );

  trap_status #(
    .XLEN      (XLEN),
    .NWIN      (NWIN),
    .CWP_W     (CWP_W),
    .RST_SUPER (RST_SUPER)
  ) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .tt_i   (tt_sel),
    .et_o   (et),
    .s_o    (s),
    .ps_o   (ps),
    .cwp_o  (cwp),
    .tt_o   (tt_q),
    .psr_o  (psr)
  );

  assign tbr = {tba_i, tt_q, 4'b0000};

  trap_fsm #(
    .XLEN (XLEN)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .pc_i        (pc_i),
    .npc_i       (npc_i),
    .ret_pc_i    (ret_pc_i),
    .ret_npc_i   (ret_npc_i),
    .psr_i       (psr),
    .tbr_i       (tbr),
    .state_o     (state),
    .rf_we_o     (rf_we_o),
    .rf_idx_o    (rf_idx_o),
    .rf_data_o   (rf_data_o),
    .fetch_o     (fetch_o),
    .fetch_pc_o  (fetch_pc_o),
    .fetch_npc_o (fetch_npc_o),
    .fatal_o     (fatal_o)
  );

  assign busy_o   = (state != S_IDLE) && (state != S_HALT);
  assign rf_win_o = cwp;
  assign et_o     = et;
  assign s_o      = s;
  assign ps_o     = ps;
  assign cwp_o    = cwp;
  assign tbr_o    = tbr;

  p_saved_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_idx_o == 2'd2) |-> (rf_data_o[PSR_ET] && !et && s));
  p_fatal_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> $stable({et, s, ps, cwp, tt_q}));
  p_sw_type_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE && et && !trap_req_i && sw_trap_i)
      |=> (tt_q == {1'b1, $past(sw_arg_i)}));
endmodule

// File: tb/trap_seq_tb.sv
module trap_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [7:0]  trap_tt = 8'h0;
  logic        sw_trap = 1'b0;
  logic [6:0]  sw_arg = 7'h0;
  logic        ret_req = 1'b0;
  logic [31:0] ret_pc = 32'h0, ret_npc = 32'h0, pc = 32'h0, npc = 32'h0;
  logic [19:0] tba = 20'h40000;

  logic        busy, fatal, rf_we, fetch, et, s, ps;
  logic [2:0]  rf_win, cwp;
  logic [1:0]  rf_idx;
  logic [31:0] rf_data, fetch_pc, fetch_npc, tbr;

  logic        b_busy, b_fatal, b_rf_we, b_fetch, b_et, b_s, b_ps;
  logic [2:0]  b_rf_win, b_cwp;
  logic [1:0]  b_rf_idx;
  logic [31:0] b_rf_data, b_fetch_pc, b_fetch_npc, b_tbr;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_seq #(.XLEN(32), .NWIN(NW), .RST_SUPER(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req), .trap_tt_i(trap_tt),
    .sw_trap_i(sw_trap), .sw_arg_i(sw_arg), .ret_req_i(ret_req), .ret_pc_i(ret_pc),
    .ret_npc_i(ret_npc), .pc_i(pc), .npc_i(npc), .tba_i(tba), .busy_o(busy),
    .fatal_o(fatal), .rf_we_o(rf_we), .rf_win_o(rf_win), .rf_idx_o(rf_idx),
    .rf_data_o(rf_data), .fetch_o(fetch), .fetch_pc_o(fetch_pc), .fetch_npc_o(fetch_npc),
    .et_o(et), .s_o(s), .ps_o(ps), .cwp_o(cwp), .tbr_o(tbr));

  trap_seq #(.XLEN(32), .NWIN(NW), .RST_SUPER(1'b1)) u_dut_sup (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req), .trap_tt_i(trap_tt),
    .sw_trap_i(sw_trap), .sw_arg_i(sw_arg), .ret_req_i(ret_req), .ret_pc_i(ret_pc),
    .ret_npc_i(ret_npc), .pc_i(pc), .npc_i(npc), .tba_i(tba), .busy_o(b_busy),
    .fatal_o(b_fatal), .rf_we_o(b_rf_we), .rf_win_o(b_rf_win), .rf_idx_o(b_rf_idx),
    .rf_data_o(b_rf_data), .fetch_o(b_fetch), .fetch_pc_o(b_fetch_pc), .fetch_npc_o(b_fetch_npc),
    .et_o(b_et), .s_o(b_s), .ps_o(b_ps), .cwp_o(b_cwp), .tbr_o(b_tbr));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference: one queue entry per expected busy cycle
  typedef struct {
    bit          we;
    int          idx;
    logic [31:0] data;
    bit          fe;
    logic [31:0] fpc;
    logic [31:0] fnpc;
  } exp_t;

  exp_t        q[$];
  bit          m_et = 1'b1, m_s = 1'b0, m_ps = 1'b0, m_fatal = 1'b0;
  int          m_cwp = 0;
  logic [7:0]  m_tt = 8'h0;

  task automatic model_accept();
    bit          take;
    logic [7:0]  t;
    logic [31:0] word, base;
    exp_t        e;
    take = 1'b0;
    t    = 8'h0;
    if (trap_req) begin
      take = 1'b1; t = trap_tt;
    end else if (sw_trap) begin
      take = 1'b1; t = 8'h80 + {1'b0, sw_arg};
    end else if (ret_req) begin
      if (!m_s) begin
        take = 1'b1; t = 8'h03;
      end else if (m_et) begin
        take = 1'b1; t = 8'h02;
      end else begin
        e = '{0, 0, 32'h0, 1, ret_pc, ret_npc};
        q.push_back(e);
        m_et  = 1'b1;
        m_s   = m_ps;
        m_cwp = (m_cwp + 1) % NW;
      end
    end
    if (take) begin
      if (!m_et) begin
        m_fatal = 1'b1;
      end else begin
        word = 32'(m_cwp);
        word[7] = m_s; word[6] = m_ps; word[5] = m_et;
        m_ps  = m_s;
        m_s   = 1'b1;
        m_et  = 1'b0;
        m_cwp = (m_cwp + NW - 1) % NW;
        m_tt  = t;
        base  = {tba, t, 4'h0};
        e = '{1, 0, pc, 0, 32'h0, 32'h0};   q.push_back(e);
        e = '{1, 1, npc, 0, 32'h0, 32'h0};  q.push_back(e);
        e = '{1, 2, word, 0, 32'h0, 32'h0}; q.push_back(e);
        e = '{0, 0, 32'h0, 1, base, base + 32'd4}; q.push_back(e);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_et = 1'b1; m_s = 1'b0; m_ps = 1'b0; m_cwp = 0; m_tt = 8'h0; m_fatal = 1'b0;
    end else if (m_fatal) begin
    end else if (q.size() != 0) begin
      void'(q.pop_front());
    end else begin
      model_accept();
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_t e;
      e = '{0, 0, 32'h0, 0, 32'h0, 32'h0};
      if (q.size() != 0) e = q[0];
      chk("R2 et", {31'h0, et}, {31'h0, m_et});
      chk("R2 s", {31'h0, s}, {31'h0, m_s});
      chk("R2 ps", {31'h0, ps}, {31'h0, m_ps});
      chk("R2 cwp", {29'h0, cwp}, 32'(m_cwp));
      chk("R4 tbr", tbr, {tba, m_tt, 4'h0});
      chk("R6 fatal", {31'h0, fatal}, {31'h0, m_fatal});
      chk("R9 busy", {31'h0, busy}, {31'h0, (q.size() != 0)});
      chk("R3 we", {31'h0, rf_we}, {31'h0, e.we});
      if (e.we) begin
        chk("R3 idx", {30'h0, rf_idx}, 32'(e.idx));
        chk("R3 data", rf_data, e.data);
        chk("R3 win", {29'h0, rf_win}, 32'(m_cwp));
      end
      chk("R4 fetch", {31'h0, fetch}, {31'h0, e.fe});
      if (e.fe) begin
        chk("R4 fpc", fetch_pc, e.fpc);
        chk("R4 fnpc", fetch_npc, e.fnpc);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      finish_up();
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic hw_trap(input logic [7:0] t, input logic [31:0] p);
    pc = p; npc = p + 32'd4; trap_tt = t; trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  task automatic sw_trap_go(input logic [6:0] a, input logic [31:0] p);
    pc = p; npc = p + 32'd4; sw_arg = a; sw_trap = 1'b1;
    @(negedge clk);
    sw_trap = 1'b0;
  endtask

  task automatic do_ret(input logic [31:0] rp, input logic [31:0] rn);
    ret_pc = rp; ret_npc = rn; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 et", {31'h0, et}, 32'h1);
    chk("R1 s", {31'h0, s}, 32'h0);
    chk("R1 ps", {31'h0, ps}, 32'h0);
    chk("R1 cwp", {29'h0, cwp}, 32'h0);
    chk("R1 tbr", tbr, {tba, 8'h00, 4'h0});
    chk("R1 idle", {28'h0, busy, fatal, rf_we, fetch}, 32'h0);
    chk("R1 sup_s", {31'h0, b_s}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: return in user mode -> privileged; supervisor instance -> illegal
    pc = 32'h0000_1000; npc = 32'h0000_1004;
    do_ret(32'h0000_2000, 32'h0000_2004);
    chk("R8 priv_tt", {24'h0, tbr[11:4]}, 32'h03);
    chk("R8 illegal_tt", {24'h0, b_tbr[11:4]}, 32'h02);
    chk("R8 saved_pc", rf_data, 32'h0000_1000);
    chk("R2 cwp_wrap", {29'h0, cwp}, 32'd7);
    wait_idle();

    // R6: trap while traps disabled
    hw_trap(8'h2a, 32'h0000_3000);
    chk("R6 fatal", {31'h0, fatal}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 sticky", {31'h0, fatal}, 32'h1);
    chk("R6 quiet", {30'h0, rf_we, fetch}, 32'h0);
    chk("R6 cwp_kept", {29'h0, cwp}, 32'd7);
    chk("R6 tt_kept", {24'h0, tbr[11:4]}, 32'h03);

    rst_n = 1'b0;
    tba = 20'h12345;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4 hardware trap, then return skipping the trapped instruction
    hw_trap(8'h11, 32'h0000_4000);
    chk("R3 first_write", {rf_we, 29'h0, rf_idx}, {1'b1, 31'h0});
    chk("R3 win", {29'h0, rf_win}, 32'd7);
    wait_idle();
    do_ret(32'h0000_4004, 32'h0000_4008);
    chk("R7 fpc", fetch_pc, 32'h0000_4004);
    chk("R7 fnpc", fetch_npc, 32'h0000_4008);
    chk("R7 flags", {29'h0, et, s, ps}, 32'b100);
    chk("R7 cwp_wrap", {29'h0, cwp}, 32'd0);
    wait_idle();

    // R5 software trap; R9 requests during the sequence are ignored
    sw_trap_go(7'h05, 32'h0000_5000);
    trap_req = 1'b1; trap_tt = 8'hee; ret_req = 1'b1; sw_trap = 1'b1;
    @(negedge clk);
    @(negedge clk);
    trap_req = 1'b0; ret_req = 1'b0; sw_trap = 1'b0;
    chk("R5 sw_tt", {24'h0, tbr[11:4]}, 32'h85);
    chk("R9 no_restart", {29'h0, cwp}, 32'd7);
    wait_idle();
    do_ret(32'h0000_5000, 32'h0000_5004);
    wait_idle();

    // R5 priority: hardware over software over return
    pc = 32'h0000_6000; npc = 32'h0000_6004;
    trap_tt = 8'h09; sw_arg = 7'h11; ret_pc = 32'h0; ret_npc = 32'h0;
    trap_req = 1'b1; sw_trap = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0; sw_trap = 1'b0; ret_req = 1'b0;
    chk("R5 hw_wins", {24'h0, tbr[11:4]}, 32'h09);
    wait_idle();
    do_ret(32'h0000_6004, 32'h0000_6008);
    wait_idle();

    // R5 software over return
    pc = 32'h0000_6100; npc = 32'h0000_6104;
    sw_arg = 7'h00; sw_trap = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    sw_trap = 1'b0; ret_req = 1'b0;
    chk("R5 sw_zero", {24'h0, tbr[11:4]}, 32'h80);
    wait_idle();
    do_ret(32'h0000_6100, 32'h0000_6104);
    wait_idle();

    // assorted trap/return rounds
    for (int i = 0; i < 6; i++) begin
      hw_trap(8'h20 + 8'(i * 13), 32'h0001_0000 + 32'(i * 64));
      wait_idle();
      if (i[0]) do_ret(32'h0001_0004 + 32'(i * 64), 32'h0001_0008 + 32'(i * 64));
      else      do_ret(32'h0001_0000 + 32'(i * 64), 32'h0001_0004 + 32'(i * 64));
      wait_idle();
      sw_trap_go(7'(i * 19), 32'h0002_0000 + 32'(i * 32));
      wait_idle();
      do_ret(32'h0002_0004 + 32'(i * 32), 32'h0002_0008 + 32'(i * 32));
      wait_idle();
    end

    finish_up();
  end
endmodule